// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers interrupt requests from a set of devices. Each device has a 3-bit urgency level, and a higher number means more urgent. A device takes part only while both its ready flag and its interrupt-enable flag are set. Among the devices that take part, the block picks the one with the highest level. On a tie, it picks the device with the lowest index. It then compares the winner's level with the urgency level of the program that is running now.

The processor raises a one-cycle `sample` strobe at each instruction boundary, which falls after the store phase and before the next fetch. On that clock edge the block registers three values:
- the interrupt decision;
- the index of the winning device;
- the level of the winning device.

These outputs stay unchanged until the next strobe. The processor uses the registered decision to either continue with the next instruction or branch to the service routine for the reported device. The winner encoder can be built as a balanced comparison tree or as a linear scan, and a parameter selects which.

Top module: `irq_arb_top`

## Requirements
- R1: While reset is high, and after it falls until the first strobe, `irq_out`, `win_idx` and `win_lvl` are all zero.
- R2: Device i takes part in arbitration only when `dev_ready[i]` and `dev_ie[i]` are both 1. A device with only one of the two set never wins and never raises `irq_out`.
- R3: Device i's level is `dev_level[i*LVL_W +: LVL_W]`. The reported winner is a participating device whose level is the highest among all participating devices, and `win_lvl` equals that level.
- R4: When several participating devices share the highest level, `win_idx` is the lowest index among them.
- R5: `irq_out` is 1 only when the winning level is strictly greater than `cpu_level`. An equal or lower level gives `irq_out` = 0, while `win_idx` and `win_lvl` still report the winner.
- R6: In a cycle in which `sample` is 0, `irq_out`, `win_idx` and `win_lvl` keep their values, whatever the request and level inputs do.
- R7: When a strobe finds no participating device, `irq_out`, `win_idx` and `win_lvl` all become 0.
- R8: The outputs reflect the inputs present on the clock edge at which `sample` is 1. They change at that edge and not before. Input changes in the cycle after the strobe do not affect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_ready | input | NUM_DEV | Per-device ready flag |
| dev_ie | input | NUM_DEV | Per-device interrupt enable |
| dev_level | input | NUM_DEV*LVL_W | Packed per-device urgency levels, device i at bits i*LVL_W upward |
| cpu_level | input | LVL_W | Urgency level of the running program |
| sample | input | 1 | Instruction-boundary strobe, one cycle wide |
| irq_out | output | 1 | Registered interrupt decision |
| win_idx | output | IDX_W | Registered index of the winning device |
| win_lvl | output | LVL_W | Registered level of the winning device |

## Verification
The bench builds three copies of the block. The first uses the defaults: eight devices and the tree encoder. The second uses five devices with the tree encoder, so three padding leaves that can never be valid sit in the tree. The third uses eight devices with the linear scan. All three receive the same stimulus, so any difference between the two encoder variants on ties and level ordering shows up as a mismatch against one reference model. The five-device copy also shows that requests above its device count do not reach it.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic {
    ENC_LINEAR = 1'b0,
    ENC_TREE   = 1'b1
  } enc_style_e;

  // index width for a device count, never below one bit
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter int NUM_DEV = 8
) (
  input  logic [NUM_DEV-1:0] ready,
  input  logic [NUM_DEV-1:0] ie,
  output logic [NUM_DEV-1:0] req
);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign req[g] = ready[g] & ie[g];
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_arb_pkg::*;
#(
  parameter int         NUM_DEV   = 8,
  parameter int         LVL_W     = 3,
  parameter enc_style_e ENC_STYLE = ENC_TREE,
  localparam int        IDX_W     = idx_width(NUM_DEV)
) (
  input  logic [NUM_DEV-1:0]       req,
  input  logic [NUM_DEV*LVL_W-1:0] lvl,
  output logic                     win_v,
  output logic [IDX_W-1:0]         win_i,
  output logic [LVL_W-1:0]         win_l
);

  if (ENC_STYLE == ENC_TREE) begin : g_tree
    localparam int PAD = 1 << IDX_W;

    // heap layout: node k has children 2k (lower indices) and 2k+1
    logic             nv [2*PAD];
    logic [LVL_W-1:0] nl [2*PAD];
    logic [IDX_W-1:0] ni [2*PAD];

    assign nv[0] = 1'b0;
    assign nl[0] = '0;
    assign ni[0] = '0;

    for (genvar g = 0; g < PAD; g++) begin : g_leaf
      if (g < NUM_DEV) begin : g_real
        assign nv[PAD+g] = req[g];
        assign nl[PAD+g] = lvl[g*LVL_W +: LVL_W];
      end else begin : g_pad
        assign nv[PAD+g] = 1'b0;
        assign nl[PAD+g] = '0;
      end
      assign ni[PAD+g] = IDX_W'(g);
    end

    for (genvar k = 1; k < PAD; k++) begin : g_node
      logic take_lo;
      // lower-index side keeps ties
      assign take_lo = nv[2*k] && (!nv[2*k+1] || (nl[2*k] >= nl[2*k+1]));
      assign nv[k]   = nv[2*k] | nv[2*k+1];
      assign nl[k]   = take_lo ? nl[2*k] : nl[2*k+1];
      assign ni[k]   = take_lo ? ni[2*k] : ni[2*k+1];
    end

    assign win_v = nv[1];
    assign win_l = nl[1];
    assign win_i = ni[1];
  end else begin : g_linear
    always_comb begin
      win_v = 1'b0;
      win_i = '0;
      win_l = '0;
      // descending scan with >= lets the lowest index win a tie
      for (int k = NUM_DEV - 1; k >= 0; k--) begin
        if (req[k] && (!win_v || (lvl[k*LVL_W +: LVL_W] >= win_l))) begin
          win_v = 1'b1;
          win_i = IDX_W'(k);
          win_l = lvl[k*LVL_W +: LVL_W];
        end
      end
    end
  end

endmodule

// File: rtl/irq_sample_reg.sv
module irq_sample_reg #(
  parameter int LVL_W = 3,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample,
  input  logic             win_v,
  input  logic [IDX_W-1:0] win_i,
  input  logic [LVL_W-1:0] win_l,
  input  logic [LVL_W-1:0] cpu_level,
  output logic             irq_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [LVL_W-1:0] lvl_q
);

  logic preempt;
  assign preempt = win_v && (win_l > cpu_level);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
    end else if (sample) begin
      irq_q <= preempt;
      idx_q <= win_v ? win_i : '0;
      lvl_q <= win_v ? win_l : '0;
    end
  end

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int         NUM_DEV   = 8,
  parameter int         LVL_W     = 3,
  parameter enc_style_e ENC_STYLE = ENC_TREE,
  localparam int        IDX_W     = idx_width(NUM_DEV)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_DEV-1:0]       dev_ready,
  input  logic [NUM_DEV-1:0]       dev_ie,
  input  logic [NUM_DEV*LVL_W-1:0] dev_level,
  input  logic [LVL_W-1:0]         cpu_level,
  input  logic                     sample,
  output logic                     irq_out,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);

  logic [NUM_DEV-1:0] req;
  logic               enc_v;
  logic [IDX_W-1:0]   enc_i;
  logic [LVL_W-1:0]   enc_l;

  irq_req_gate #(.NUM_DEV(NUM_DEV)) u_gate (
    .ready (dev_ready),
    .ie    (dev_ie),
    .req   (req)
  );

  irq_prio_enc #(
    .NUM_DEV   (NUM_DEV),
    .LVL_W     (LVL_W),
    .ENC_STYLE (ENC_STYLE)
  ) u_enc (
    .req   (req),
    .lvl   (dev_level),
    .win_v (enc_v),
    .win_i (enc_i),
    .win_l (enc_l)
  );

  irq_sample_reg #(.LVL_W(LVL_W), .IDX_W(IDX_W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .sample    (sample),
    .win_v     (enc_v),
    .win_i     (enc_i),
    .win_l     (enc_l),
    .cpu_level (cpu_level),
    .irq_q     (irq_out),
    .idx_q     (win_idx),
    .lvl_q     (win_lvl)
  );

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int NUM_DEV = 8,
  parameter int LVL_W   = 3,
  parameter int IDX_W   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_DEV-1:0]       dev_ready,
  input logic [NUM_DEV-1:0]       dev_ie,
  input logic [NUM_DEV*LVL_W-1:0] dev_level,
  input logic [LVL_W-1:0]         cpu_level,
  input logic                     sample,
  input logic                     irq_out,
  input logic [IDX_W-1:0]         win_idx,
  input logic [LVL_W-1:0]         win_lvl
);

  logic                     samp_d;
  logic [NUM_DEV-1:0]       req_s;
  logic [NUM_DEV*LVL_W-1:0] lvl_s;
  logic [LVL_W-1:0]         cpu_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_d <= 1'b0;
      req_s  <= '0;
      lvl_s  <= '0;
      cpu_s  <= '0;
    end else begin
      samp_d <= sample;
      if (sample) begin
        req_s <= dev_ready & dev_ie;
        lvl_s <= dev_level;
        cpu_s <= cpu_level;
      end
    end
  end

  logic idx_ok, idx_req, lvl_match, higher_seen, tie_lower;
  always_comb begin
    idx_ok      = int'(win_idx) < NUM_DEV;
    idx_req     = 1'b0;
    lvl_match   = 1'b0;
    higher_seen = 1'b0;
    tie_lower   = 1'b0;
    for (int k = 0; k < NUM_DEV; k++) begin
      if (k == int'(win_idx)) begin
        idx_req   = req_s[k];
        lvl_match = lvl_s[k*LVL_W +: LVL_W] == win_lvl;
      end
      if (req_s[k] && lvl_s[k*LVL_W +: LVL_W] > win_lvl) higher_seen = 1'b1;
      if (req_s[k] && lvl_s[k*LVL_W +: LVL_W] == win_lvl && k < int'(win_idx))
        tie_lower = 1'b1;
    end
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (!irq_out && win_idx == '0 && win_lvl == '0));

  assert_winner_gated_R2: assert property (@(posedge clk) disable iff (rst)
    (samp_d && req_s != '0) |-> (idx_ok && idx_req));

  assert_winner_highest_R3: assert property (@(posedge clk) disable iff (rst)
    (samp_d && req_s != '0) |-> (lvl_match && !higher_seen));

  assert_tie_lowest_R4: assert property (@(posedge clk) disable iff (rst)
    (samp_d && req_s != '0) |-> !tie_lower);

  assert_strict_above_R5: assert property (@(posedge clk) disable iff (rst)
    (samp_d && irq_out) |-> (win_lvl > cpu_s));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sample)) |->
      ($stable(irq_out) && $stable(win_idx) && $stable(win_lvl)));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (samp_d && req_s == '0) |-> (!irq_out && win_idx == '0 && win_lvl == '0));

endmodule

bind irq_arb_top irq_arb_chk #(
  .NUM_DEV (NUM_DEV),
  .LVL_W   (LVL_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dev_ready (dev_ready),
  .dev_ie    (dev_ie),
  .dev_level (dev_level),
  .cpu_level (cpu_level),
  .sample    (sample),
  .irq_out   (irq_out),
  .win_idx   (win_idx),
  .win_lvl   (win_lvl)
);

// File: tb/sim_irq_arb_top.sv
`timescale 1ns/1ps
module sim_irq_arb_top;
  import irq_arb_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rdy = '0;
  logic [7:0]  ie  = '0;
  logic [23:0] lv  = '0;
  logic [2:0]  cpu = '0;
  logic        smp = 1'b0;

  logic       irq0, irq1, irq2;
  logic [2:0] idx0, idx1, idx2;
  logic [2:0] lvl0, lvl1, lvl2;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  irq_arb_top u0 (
    .clk(clk), .rst(rst), .dev_ready(rdy), .dev_ie(ie), .dev_level(lv),
    .cpu_level(cpu), .sample(smp), .irq_out(irq0), .win_idx(idx0), .win_lvl(lvl0)
  );

  irq_arb_top #(.NUM_DEV(5), .ENC_STYLE(ENC_TREE)) u1 (
    .clk(clk), .rst(rst), .dev_ready(rdy[4:0]), .dev_ie(ie[4:0]), .dev_level(lv[14:0]),
    .cpu_level(cpu), .sample(smp), .irq_out(irq1), .win_idx(idx1), .win_lvl(lvl1)
  );

  irq_arb_top #(.NUM_DEV(8), .ENC_STYLE(ENC_LINEAR)) u2 (
    .clk(clk), .rst(rst), .dev_ready(rdy), .dev_ie(ie), .dev_level(lv),
    .cpu_level(cpu), .sample(smp), .irq_out(irq2), .win_idx(idx2), .win_lvl(lvl2)
  );

  // expected values for the first n devices
  int e_irq [3];
  int e_idx [3];
  int e_lvl [3];

  task automatic model(input int n, output int o_irq, output int o_idx, output int o_lvl);
    int best = -1;
    o_idx = 0;
    for (int i = 0; i < n; i++) begin
      if (rdy[i] && ie[i] && int'(lv[i*3 +: 3]) > best) begin
        best  = int'(lv[i*3 +: 3]);
        o_idx = i;
      end
    end
    o_lvl = (best < 0) ? 0 : best;
    o_irq = (best > int'(cpu)) ? 1 : 0;
  endtask

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "u0.irq", int'(irq0), e_irq[0]);
    chk(tag, "u0.idx", int'(idx0), e_idx[0]);
    chk(tag, "u0.lvl", int'(lvl0), e_lvl[0]);
    chk(tag, "u1.irq", int'(irq1), e_irq[1]);
    chk(tag, "u1.idx", int'(idx1), e_idx[1]);
    chk(tag, "u1.lvl", int'(lvl1), e_lvl[1]);
    chk(tag, "u2.irq", int'(irq2), e_irq[2]);
    chk(tag, "u2.idx", int'(idx2), e_idx[2]);
    chk(tag, "u2.lvl", int'(lvl2), e_lvl[2]);
  endtask

  task automatic compute_exp();
    model(8, e_irq[0], e_idx[0], e_lvl[0]);
    model(5, e_irq[1], e_idx[1], e_lvl[1]);
    model(8, e_irq[2], e_idx[2], e_lvl[2]);
  endtask

  // strobe for one cycle, then check at the negedge after the capturing edge
  task automatic strobe_check(input string tag);
    @(negedge clk);
    smp = 1'b1;
    compute_exp();
    @(negedge clk);
    smp = 1'b0;
    compare_all(tag);
  endtask

  task automatic set_lv(input int d, input int v);
    lv[d*3 +: 3] = 3'(v);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rdy = '1; ie = '1; lv = '1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin e_irq[k] = 0; e_idx[k] = 0; e_lvl[k] = 0; end
    compare_all("R1 in reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    compare_all("R1 after reset");
  endtask

  task automatic t_gate();
    rdy = '0; ie = '0; lv = '0; cpu = 3'd0;
    rdy[3] = 1'b1; set_lv(3, 7);
    ie[4]  = 1'b1; set_lv(4, 7);
    rdy[1] = 1'b1; ie[1] = 1'b1; set_lv(1, 2);
    strobe_check("R2 gating");
    chk("R2", "u0.idx", int'(idx0), 1);
    chk("R2", "u0.lvl", int'(lvl0), 2);
  endtask

  task automatic t_highest();
    rdy = '1; ie = '1; cpu = 3'd1;
    set_lv(0, 1); set_lv(1, 3); set_lv(2, 0); set_lv(3, 4);
    set_lv(4, 2); set_lv(5, 3); set_lv(6, 5); set_lv(7, 2);
    strobe_check("R3 highest");
    chk("R3", "u0.idx", int'(idx0), 6);
    chk("R3", "u1.idx", int'(idx1), 3);
    set_lv(0, 7);
    strobe_check("R3 device0 top");
    chk("R3", "u2.idx", int'(idx2), 0);
  endtask

  task automatic t_tie();
    rdy = '1; ie = '1; cpu = 3'd0;
    for (int d = 0; d < 8; d++) set_lv(d, 1);
    set_lv(2, 6); set_lv(4, 6); set_lv(7, 6);
    strobe_check("R4 tie");
    chk("R4", "u0.idx", int'(idx0), 2);
    chk("R4", "u2.idx", int'(idx2), 2);
    rdy[2] = 1'b0;
    strobe_check("R4 tie next");
    chk("R4", "u0.idx", int'(idx0), 4);
    rdy[4] = 1'b0;
    strobe_check("R4 tie last");
    chk("R4", "u0.idx", int'(idx0), 7);
    chk("R4", "u1.lvl", int'(lvl1), 1);
  endtask

  task automatic t_strict();
    rdy = '0; ie = '0; lv = '0;
    rdy[0] = 1'b1; ie[0] = 1'b1; set_lv(0, 4);
    cpu = 3'd4; strobe_check("R5 equal");
    chk("R5", "u0.irq equal", int'(irq0), 0);
    chk("R5", "u0.lvl equal", int'(lvl0), 4);
    cpu = 3'd3; strobe_check("R5 above");
    chk("R5", "u0.irq above", int'(irq0), 1);
    cpu = 3'd5; strobe_check("R5 below");
    set_lv(0, 7); cpu = 3'd7; strobe_check("R5 top equal");
    set_lv(0, 0); cpu = 3'd0; strobe_check("R5 zero equal");
    set_lv(0, 6); cpu = 3'd0; strobe_check("R5 six over zero");
  endtask

  task automatic t_hold();
    rdy = '1; ie = '1; cpu = 3'd2;
    for (int d = 0; d < 8; d++) set_lv(d, d % 4);
    set_lv(5, 6);
    strobe_check("R6 setup");
    @(negedge clk);
    rdy = '0; lv = '1; cpu = 3'd0;
    repeat (4) @(negedge clk);
    compare_all("R6 hold");
    rdy = '1; ie = '0;
    repeat (3) @(negedge clk);
    compare_all("R6 hold ie off");
  endtask

  task automatic t_latency();
    rdy = '0; ie = '0; lv = '0; cpu = 3'd0;
    @(negedge clk);
    rdy[1] = 1'b1; ie[1] = 1'b1; set_lv(1, 5);
    smp = 1'b1;
    compare_all("R8 before edge");
    compute_exp();
    @(negedge clk);
    smp = 1'b0;
    rdy[1] = 1'b0; rdy[0] = 1'b1; ie[0] = 1'b1; set_lv(0, 7);
    compare_all("R8 after edge");
    @(negedge clk);
    compare_all("R8 late change ignored");
  endtask

  task automatic t_idle();
    rdy = '1; ie = '1; lv = '1; cpu = 3'd0;
    strobe_check("R7 busy");
    rdy = '0;
    strobe_check("R7 idle");
    chk("R7", "u0.irq", int'(irq0), 0);
    chk("R7", "u0.idx", int'(idx0), 0);
    rdy = 8'hE0; ie = 8'hE0;
    strobe_check("R7 u1 sees none");
    chk("R7", "u1.irq", int'(irq1), 0);
    chk("R7", "u1.lvl", int'(lvl1), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_gate();
    t_highest();
    t_tie();
    t_strict();
    t_hold();
    t_latency();
    t_idle();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

endmodule